// File: doc/BRIEF.md
# Two-Stage Memory Attribute Combiner

This block takes the memory attribute descriptors produced by a first-stage and a second-stage address translation and reduces them to the single descriptor that the memory system sees. Each stage supplies a fault flag, a memory type, a device ordering class, and inner and outer cacheability with allocation hints and a transient flag. It also supplies shareability flags and an allocation-tag flag. A force-writeback control, gated by a feature-present input, lets the second stage override the first stage's cacheability.

Merging works on a "most restrictive wins" basis for memory type, device ordering and cacheability. When force-writeback is active, a separate path uses the second stage's inner code to force, inherit or suppress cacheability, and it rewrites the hints. After merging, defaults are applied so that Device and fully Non-cacheable results are always reported as shareable. The merge is combinational, and its result is captured in an output register with a valid flag that trails the input valid by one cycle.

Top module: `attr_combine`

## Requirements
- R1: If stage 1 faults, the output is the stage-1 descriptor and address, passed unchanged with fault_o high. If only stage 2 faults, the output is the stage-2 descriptor and address. Without a fault, pa_o carries the stage-2 address.
- R2: Force-writeback is active only when both fwb_i and fwb_feat_i are high. The result is Device (dev_o=1) when stage 2 is Device, or when stage 1 is Device and force-writeback is inactive. With force-writeback active, a stage-1 Device also gives Device unless the stage-2 inner code is 2'b10.
- R3: Device type codes are 00 most restrictive, then 01, 10, and 11 least restrictive. When both stages are Device, the lower code wins. When only one stage is Device, its code passes through. A Normal result has dtype_o = 00.
- R4: Cacheability codes are 00 Non-cacheable, 01 reserved, 10 Write-through and 11 Write-back. Without force-writeback, inner and outer are each merged separately. Either stage reserved gives 00. Otherwise either stage Non-cacheable gives Non-cacheable, then either Write-through gives Write-through, and otherwise the result is Write-back. Hints and transient come from stage 1 in each domain.
- R5: With force-writeback active, the stage-2 inner code decides the inner result. Code 10 gives Write-back, 11 takes the stage-1 inner code, and any other value gives Non-cacheable. The whole outer result copies the inner result.
- R6: With force-writeback active, hints (encoded 00 none, 01 write-allocate, 10 read-allocate, 11 read-write-allocate) follow stage 1 when neither the stage-1 inner code nor the result is Non-cacheable. They are 11 when stage 1 is Non-cacheable and the result is not, and 00 when the result is Non-cacheable. Transient comes from stage 1.
- R7: For a Normal result, sh_o and osh_o are the OR of the two stages' flags, unless R9 forces them.
- R8: tag_o of a non-faulting result is high only when stage 1 is tagged and both the inner and outer results are Write-back (11) with hints 11. A Device result is never tagged.
- R9: A Device result drives sh_o=osh_o=1 and all cacheability, hint and transient outputs to 0. A Normal result with inner and outer both 00 drives sh_o=osh_o=1.
- R10: Outputs are registered. valid_o is the valid_i of the previous cycle, and the outputs change only in a cycle after valid_i was high. Reset clears valid_o and every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input descriptors are valid |
| fwb_i | input | 1 | Force-writeback control |
| fwb_feat_i | input | 1 | Force-writeback feature present |
| s1_fault_i | input | 1 | Stage 1 fault |
| s1_dev_i | input | 1 | Stage 1 is Device (0 = Normal) |
| s1_dtype_i | input | 2 | Stage 1 device type |
| s1_in_attr_i | input | 2 | Stage 1 inner cacheability |
| s1_in_hint_i | input | 2 | Stage 1 inner hints |
| s1_in_trans_i | input | 1 | Stage 1 inner transient |
| s1_out_attr_i | input | 2 | Stage 1 outer cacheability |
| s1_out_hint_i | input | 2 | Stage 1 outer hints |
| s1_out_trans_i | input | 1 | Stage 1 outer transient |
| s1_sh_i | input | 1 | Stage 1 shareable |
| s1_osh_i | input | 1 | Stage 1 outer-shareable |
| s1_tag_i | input | 1 | Stage 1 tagged |
| s1_pa_i | input | PA_W | Stage 1 address |
| s2_fault_i | input | 1 | Stage 2 fault |
| s2_dev_i | input | 1 | Stage 2 is Device |
| s2_dtype_i | input | 2 | Stage 2 device type |
| s2_in_attr_i | input | 2 | Stage 2 inner cacheability |
| s2_in_hint_i | input | 2 | Stage 2 inner hints |
| s2_in_trans_i | input | 1 | Stage 2 inner transient |
| s2_out_attr_i | input | 2 | Stage 2 outer cacheability |
| s2_out_hint_i | input | 2 | Stage 2 outer hints |
| s2_out_trans_i | input | 1 | Stage 2 outer transient |
| s2_sh_i | input | 1 | Stage 2 shareable |
| s2_osh_i | input | 1 | Stage 2 outer-shareable |
| s2_tag_i | input | 1 | Stage 2 tagged |
| s2_pa_i | input | PA_W | Stage 2 (final) address |
| valid_o | output | 1 | Output descriptor valid |
| fault_o | output | 1 | Result fault |
| dev_o | output | 1 | Result is Device |
| dtype_o | output | 2 | Result device type |
| in_attr_o | output | 2 | Result inner cacheability |
| in_hint_o | output | 2 | Result inner hints |
| in_trans_o | output | 1 | Result inner transient |
| out_attr_o | output | 2 | Result outer cacheability |
| out_hint_o | output | 2 | Result outer hints |
| out_trans_o | output | 1 | Result outer transient |
| sh_o | output | 1 | Result shareable |
| osh_o | output | 1 | Result outer-shareable |
| tag_o | output | 1 | Result tagged |
| pa_o | output | PA_W | Result address |

## Verification
Several functions can meet in one cycle: the force-writeback demotion of a stage-1 Device to Normal, the forced Write-back with rewritten hints, and the tag-eligibility rule. The bench presents a stage-1 Device that is tagged and has Non-cacheable inner fields, together with a stage-2 inner code of 2'b10, while force-writeback is active. It expects a Normal, Write-back, read-write-allocate, tagged result in the next cycle. The same inputs are then repeated with the feature input low, and the bench expects a Device result that is shareable and not tagged.

// File: rtl/attr_pkg.sv
package attr_pkg;
  localparam logic [1:0] CA_NC   = 2'b00;
  localparam logic [1:0] CA_RSV  = 2'b01;
  localparam logic [1:0] CA_WT   = 2'b10;
  localparam logic [1:0] CA_WB   = 2'b11;
  localparam logic [1:0] HINT_NONE = 2'b00;
  localparam logic [1:0] HINT_RWA  = 2'b11;
  localparam int unsigned N_DOM = 2;  // 0 inner, 1 outer

  typedef struct packed {
    logic [1:0] ca;
    logic [1:0] hint;
    logic       trans;
  } dom_t;

  typedef struct packed {
    logic       fault;
    logic       dev;
    logic [1:0] dtype;
    dom_t       inr;
    dom_t       outr;
    logic       sh;
    logic       osh;
    logic       tag;
  } desc_t;
endpackage

// File: rtl/attr_dev_merge.sv
module attr_dev_merge (
  input  logic       s1_dev_i,
  input  logic       s2_dev_i,
  input  logic [1:0] s1_dtype_i,
  input  logic [1:0] s2_dtype_i,
  output logic [1:0] dtype_o
);
  always_comb begin
    if (!s1_dev_i)      dtype_o = s2_dtype_i;
    else if (!s2_dev_i) dtype_o = s1_dtype_i;
    else                dtype_o = (s1_dtype_i < s2_dtype_i) ? s1_dtype_i : s2_dtype_i;
  end
endmodule

// File: rtl/attr_dom_merge.sv
module attr_dom_merge
  import attr_pkg::*;
(
  input  dom_t s1_i,
  input  dom_t s2_i,
  output dom_t res_o
);
  always_comb begin
    res_o.hint  = s1_i.hint;
    res_o.trans = s1_i.trans;
    if (s1_i.ca == CA_RSV || s2_i.ca == CA_RSV)     res_o.ca = CA_NC;
    else if (s1_i.ca == CA_NC || s2_i.ca == CA_NC)  res_o.ca = CA_NC;
    else if (s1_i.ca == CA_WT || s2_i.ca == CA_WT)  res_o.ca = CA_WT;
    else                                            res_o.ca = CA_WB;
  end
endmodule

// File: rtl/attr_fwb_merge.sv
module attr_fwb_merge
  import attr_pkg::*;
(
  input  dom_t       s1_inr_i,
  input  logic [1:0] s2_ca_i,
  output dom_t       res_o
);
  logic [1:0] ca;

  always_comb begin
    case (s2_ca_i)
      CA_WT:   ca = CA_WB;
      CA_WB:   ca = s1_inr_i.ca;
      default: ca = CA_NC;
    endcase
  end

  always_comb begin
    res_o.ca    = ca;
    res_o.trans = s1_inr_i.trans;
    if (ca == CA_NC)               res_o.hint = HINT_NONE;
    else if (s1_inr_i.ca == CA_NC) res_o.hint = HINT_RWA;
    else                           res_o.hint = s1_inr_i.hint;
  end
endmodule

// File: rtl/attr_combine.sv
module attr_combine
  import attr_pkg::*;
#(
  parameter int unsigned PA_W = 48
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            fwb_i,
  input  logic            fwb_feat_i,
  input  logic            s1_fault_i,
  input  logic            s1_dev_i,
  input  logic [1:0]      s1_dtype_i,
  input  logic [1:0]      s1_in_attr_i,
  input  logic [1:0]      s1_in_hint_i,
  input  logic            s1_in_trans_i,
  input  logic [1:0]      s1_out_attr_i,
  input  logic [1:0]      s1_out_hint_i,
  input  logic            s1_out_trans_i,
  input  logic            s1_sh_i,
  input  logic            s1_osh_i,
  input  logic            s1_tag_i,
  input  logic [PA_W-1:0] s1_pa_i,
  input  logic            s2_fault_i,
  input  logic            s2_dev_i,
  input  logic [1:0]      s2_dtype_i,
  input  logic [1:0]      s2_in_attr_i,
  input  logic [1:0]      s2_in_hint_i,
  input  logic            s2_in_trans_i,
  input  logic [1:0]      s2_out_attr_i,
  input  logic [1:0]      s2_out_hint_i,
  input  logic            s2_out_trans_i,
  input  logic            s2_sh_i,
  input  logic            s2_osh_i,
  input  logic            s2_tag_i,
  input  logic [PA_W-1:0] s2_pa_i,
  output logic            valid_o,
  output logic            fault_o,
  output logic            dev_o,
  output logic [1:0]      dtype_o,
  output logic [1:0]      in_attr_o,
  output logic [1:0]      in_hint_o,
  output logic            in_trans_o,
  output logic [1:0]      out_attr_o,
  output logic [1:0]      out_hint_o,
  output logic            out_trans_o,
  output logic            sh_o,
  output logic            osh_o,
  output logic            tag_o,
  output logic [PA_W-1:0] pa_o
);
  desc_t s1, s2, merged, desc_q;
  dom_t  s1_dom [N_DOM];
  dom_t  s2_dom [N_DOM];
  dom_t  std_dom [N_DOM];
  dom_t  fwb_dom;
  logic  [1:0] dt_merged;
  logic  [PA_W-1:0] pa_d, pa_q;
  logic  fwb_on, is_dev, valid_q;

  assign s1 = '{fault: s1_fault_i, dev: s1_dev_i, dtype: s1_dtype_i,
                inr: '{ca: s1_in_attr_i, hint: s1_in_hint_i, trans: s1_in_trans_i},
                outr: '{ca: s1_out_attr_i, hint: s1_out_hint_i, trans: s1_out_trans_i},
                sh: s1_sh_i, osh: s1_osh_i, tag: s1_tag_i};
  assign s2 = '{fault: s2_fault_i, dev: s2_dev_i, dtype: s2_dtype_i,
                inr: '{ca: s2_in_attr_i, hint: s2_in_hint_i, trans: s2_in_trans_i},
                outr: '{ca: s2_out_attr_i, hint: s2_out_hint_i, trans: s2_out_trans_i},
                sh: s2_sh_i, osh: s2_osh_i, tag: s2_tag_i};

  assign s1_dom[0] = s1.inr;
  assign s1_dom[1] = s1.outr;
  assign s2_dom[0] = s2.inr;
  assign s2_dom[1] = s2.outr;

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    attr_dom_merge i_dom (
      .s1_i  (s1_dom[d]),
      .s2_i  (s2_dom[d]),
      .res_o (std_dom[d])
    );
  end

  attr_fwb_merge i_fwb (
    .s1_inr_i (s1.inr),
    .s2_ca_i  (s2.inr.ca),
    .res_o    (fwb_dom)
  );

  attr_dev_merge i_dev (
    .s1_dev_i   (s1.dev),
    .s2_dev_i   (s2.dev),
    .s1_dtype_i (s1.dtype),
    .s2_dtype_i (s2.dtype),
    .dtype_o    (dt_merged)
  );

  assign fwb_on = fwb_i & fwb_feat_i;
  assign is_dev = s2.dev | (s1.dev & (!fwb_on | (s2.inr.ca != CA_WT)));

  always_comb begin
    merged = '0;
    pa_d   = s2_pa_i;
    if (s1.fault) begin
      merged = s1;
      pa_d   = s1_pa_i;
    end else if (s2.fault) begin
      merged = s2;
    end else if (is_dev) begin
      merged.dev   = 1'b1;
      merged.dtype = dt_merged;
      merged.sh    = 1'b1;
      merged.osh   = 1'b1;
    end else begin
      merged.inr  = fwb_on ? fwb_dom : std_dom[0];
      merged.outr = fwb_on ? fwb_dom : std_dom[1];
      merged.sh   = s1.sh | s2.sh;
      merged.osh  = s1.osh | s2.osh;
      merged.tag  = s1.tag &&
                    merged.inr.ca == CA_WB && merged.inr.hint == HINT_RWA &&
                    merged.outr.ca == CA_WB && merged.outr.hint == HINT_RWA;
      if (merged.inr.ca == CA_NC && merged.outr.ca == CA_NC) begin
        merged.sh  = 1'b1;
        merged.osh = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      desc_q  <= '0;
      pa_q    <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        desc_q <= merged;
        pa_q   <= pa_d;
      end
    end
  end

  assign valid_o     = valid_q;
  assign fault_o     = desc_q.fault;
  assign dev_o       = desc_q.dev;
  assign dtype_o     = desc_q.dtype;
  assign in_attr_o   = desc_q.inr.ca;
  assign in_hint_o   = desc_q.inr.hint;
  assign in_trans_o  = desc_q.inr.trans;
  assign out_attr_o  = desc_q.outr.ca;
  assign out_hint_o  = desc_q.outr.hint;
  assign out_trans_o = desc_q.outr.trans;
  assign sh_o        = desc_q.sh;
  assign osh_o       = desc_q.osh;
  assign tag_o       = desc_q.tag;
  assign pa_o        = pa_q;

  p_s1_fault_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && s1_fault_i |=> fault_o && pa_o == $past(s1_pa_i));

  p_dev_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && s1_dev_i && s2_dev_i && !s1_fault_i && !s2_fault_i
    |=> dev_o && dtype_o <= $past(s1_dtype_i) && dtype_o <= $past(s2_dtype_i));

  p_fwb_outer_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && fwb_i && fwb_feat_i && !s1_fault_i && !s2_fault_i
    |=> dev_o || (out_attr_o == in_attr_o && out_hint_o == in_hint_o));

  p_tag_ok_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !fault_o && tag_o
    |-> !dev_o && in_attr_o == CA_WB && in_hint_o == HINT_RWA
        && out_attr_o == CA_WB && out_hint_o == HINT_RWA);

  p_share_def_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !fault_o && (dev_o || (in_attr_o == CA_NC && out_attr_o == CA_NC))
    |-> sh_o && osh_o);

  p_valid_lat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(pa_o) && $stable(in_attr_o) && $stable(dev_o) && !valid_o);
endmodule

// File: tb/test_attr_combine.sv
`timescale 1ns/1ps
module test_attr_combine;
  localparam int PA_W = 16;
  localparam logic [PA_W-1:0] PA1 = 16'h1111;
  localparam logic [PA_W-1:0] PA2 = 16'h2222;

  // fault, dev, dtype, ia, ih, it, oa, oh, ot, sh, osh, tag
  typedef struct packed {
    logic fault; logic dev; logic [1:0] dt;
    logic [1:0] ia; logic [1:0] ih; logic it;
    logic [1:0] oa; logic [1:0] oh; logic ot;
    logic sh; logic osh; logic tag;
  } d_t;

  logic clk = 1'b0, rst_n = 1'b0, valid = 1'b0, fwb = 1'b0, feat = 1'b0;
  d_t a = '0, b = '0;
  logic [PA_W-1:0] pa1 = PA1, pa2 = PA2;
  logic valid_o;
  d_t   res;
  logic [PA_W-1:0] pa_o;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  attr_combine #(.PA_W(PA_W)) i_attr_combine (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .fwb_i(fwb), .fwb_feat_i(feat),
    .s1_fault_i(a.fault), .s1_dev_i(a.dev), .s1_dtype_i(a.dt),
    .s1_in_attr_i(a.ia), .s1_in_hint_i(a.ih), .s1_in_trans_i(a.it),
    .s1_out_attr_i(a.oa), .s1_out_hint_i(a.oh), .s1_out_trans_i(a.ot),
    .s1_sh_i(a.sh), .s1_osh_i(a.osh), .s1_tag_i(a.tag), .s1_pa_i(pa1),
    .s2_fault_i(b.fault), .s2_dev_i(b.dev), .s2_dtype_i(b.dt),
    .s2_in_attr_i(b.ia), .s2_in_hint_i(b.ih), .s2_in_trans_i(b.it),
    .s2_out_attr_i(b.oa), .s2_out_hint_i(b.oh), .s2_out_trans_i(b.ot),
    .s2_sh_i(b.sh), .s2_osh_i(b.osh), .s2_tag_i(b.tag), .s2_pa_i(pa2),
    .valid_o(valid_o), .fault_o(res.fault), .dev_o(res.dev), .dtype_o(res.dt),
    .in_attr_o(res.ia), .in_hint_o(res.ih), .in_trans_o(res.it),
    .out_attr_o(res.oa), .out_hint_o(res.oh), .out_trans_o(res.ot),
    .sh_o(res.sh), .osh_o(res.osh), .tag_o(res.tag), .pa_o(pa_o)
  );

  function automatic d_t mk(logic f, logic dv, logic [1:0] dt, logic [1:0] ia, logic [1:0] ih,
                            logic it, logic [1:0] oa, logic [1:0] oh, logic ot,
                            logic sh, logic osh, logic tag);
    return '{f, dv, dt, ia, ih, it, oa, oh, ot, sh, osh, tag};
  endfunction

  task automatic check(string req, d_t exp, logic [PA_W-1:0] exp_pa, logic exp_v);
    n_chk++;
    if (res !== exp || pa_o !== exp_pa || valid_o !== exp_v) begin
      n_fail++;
      $display("FAIL %s: desc=%h pa=%h v=%b expected desc=%h pa=%h v=%b",
               req, res, pa_o, valid_o, exp, exp_pa, exp_v);
    end
  endtask

  // drive at negedge, registered at posedge, sampled at following negedge
  task automatic run(string req, d_t s1, d_t s2, logic f, logic ft, d_t exp, logic [PA_W-1:0] exp_pa);
    @(negedge clk);
    a = s1; b = s2; fwb = f; feat = ft; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    check(req, exp, exp_pa, 1'b1);
  endtask

  task automatic t_reset;
    check("R10 reset", '0, '0, 1'b0);
  endtask

  task automatic t_faults;
    run("R1 both fault, stage 1 wins", mk(1,0,0,2'b11,2'b11,0,2'b11,2'b11,0,1,0,1),
        mk(1,1,2'b01,0,0,0,0,0,0,0,1,0), 0, 0,
        mk(1,0,0,2'b11,2'b11,0,2'b11,2'b11,0,1,0,1), PA1);
    run("R1 stage 2 fault", mk(0,0,0,2'b11,2'b11,0,2'b11,2'b11,0,0,0,0),
        mk(1,1,2'b01,2'b10,2'b01,1,0,0,0,0,1,0), 0, 0,
        mk(1,1,2'b01,2'b10,2'b01,1,0,0,0,0,1,0), PA2);
  endtask

  task automatic t_device;
    run("R2 R9 stage 1 device", mk(0,1,2'b10,2'b11,2'b11,1,2'b11,2'b11,1,0,0,1),
        mk(0,0,0,2'b11,2'b11,0,2'b11,2'b11,0,0,0,0), 0, 0,
        mk(0,1,2'b10,0,0,0,0,0,0,1,1,0), PA2);
    run("R3 both device, stricter", mk(0,1,2'b11,0,0,0,0,0,0,0,0,0),
        mk(0,1,2'b01,0,0,0,0,0,0,0,0,0), 0, 0,
        mk(0,1,2'b01,0,0,0,0,0,0,1,1,0), PA2);
  endtask

  task automatic t_fwb_override;
    // Device demoted, forced WB, hints rewritten and tag granted in one cycle
    run("R2 R5 R6 R8 fwb demotes device", mk(0,1,2'b00,2'b00,2'b01,0,2'b00,2'b01,0,0,0,1),
        mk(0,0,0,2'b10,2'b00,0,2'b10,2'b00,0,0,0,0), 1, 1,
        mk(0,0,0,2'b11,2'b11,0,2'b11,2'b11,0,0,0,1), PA2);
    run("R2 fwb keeps device on code 11", mk(0,1,2'b00,0,0,0,0,0,0,0,0,1),
        mk(0,0,0,2'b11,2'b00,0,2'b11,2'b00,0,0,0,0), 1, 1,
        mk(0,1,2'b00,0,0,0,0,0,0,1,1,0), PA2);
    run("R2 R5 fwb needs feature", mk(0,1,2'b00,2'b00,2'b01,0,2'b00,2'b01,0,0,0,1),
        mk(0,0,0,2'b10,2'b00,0,2'b10,2'b00,0,0,0,0), 1, 0,
        mk(0,1,2'b00,0,0,0,0,0,0,1,1,0), PA2);
  endtask

  task automatic t_fwb_normal;
    run("R5 R6 fwb inherit, outer copies", mk(0,0,0,2'b10,2'b01,1,2'b11,2'b11,0,0,0,1),
        mk(0,0,0,2'b11,2'b00,0,2'b01,2'b00,0,0,1,0), 1, 1,
        mk(0,0,0,2'b10,2'b01,1,2'b10,2'b01,1,0,1,0), PA2);
    run("R5 R6 R9 fwb non-cacheable", mk(0,0,0,2'b11,2'b10,1,2'b11,2'b10,0,0,0,1),
        mk(0,0,0,2'b00,2'b00,0,2'b11,2'b00,0,0,0,0), 1, 1,
        mk(0,0,0,2'b00,2'b00,1,2'b00,2'b00,1,1,1,0), PA2);
  endtask

  task automatic t_std_merge;
    run("R4 R7 write-through wins", mk(0,0,0,2'b11,2'b01,1,2'b10,2'b10,0,1,0,1),
        mk(0,0,0,2'b10,2'b11,0,2'b11,2'b11,1,0,1,0), 0, 0,
        mk(0,0,0,2'b10,2'b01,1,2'b10,2'b10,0,1,1,0), PA2);
    run("R4 R9 reserved and NC", mk(0,0,0,2'b01,2'b10,0,2'b11,2'b11,0,0,0,0),
        mk(0,0,0,2'b11,2'b00,0,2'b00,2'b00,0,0,0,0), 0, 0,
        mk(0,0,0,2'b00,2'b10,0,2'b00,2'b11,0,1,1,0), PA2);
  endtask

  task automatic t_tag;
    run("R8 tag granted", mk(0,0,0,2'b11,2'b11,0,2'b11,2'b11,0,0,0,1),
        mk(0,0,0,2'b11,2'b00,0,2'b11,2'b00,0,0,0,0), 0, 0,
        mk(0,0,0,2'b11,2'b11,0,2'b11,2'b11,0,0,0,1), PA2);
    run("R8 tag denied by outer hint", mk(0,0,0,2'b11,2'b11,0,2'b11,2'b10,0,0,0,1),
        mk(0,0,0,2'b11,2'b00,0,2'b11,2'b00,0,0,0,0), 0, 0,
        mk(0,0,0,2'b11,2'b11,0,2'b11,2'b10,0,0,0,0), PA2);
  endtask

  task automatic t_hold;
    d_t prev;
    logic [PA_W-1:0] prev_pa;
    prev = res; prev_pa = pa_o;
    @(negedge clk);
    a = mk(1,1,2'b11,2'b10,2'b10,1,2'b10,2'b10,1,1,1,1); b = '0;
    pa1 = 16'h3333; valid = 1'b0;
    @(negedge clk);
    check("R10 hold without valid", prev, prev_pa, 1'b0);
  endtask

  initial begin
    #100_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_faults();
    t_device();
    t_fwb_override();
    t_fwb_normal();
    t_std_merge();
    t_tag();
    t_hold();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule